// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request bus and an external asynchronous static RAM that is 16 bits wide and has two byte lanes. It takes one word per request, either a read or a write, over a valid/ready handshake. It turns that request into the level sequence the memory expects. The outputs are the address, a pair of chip selects (one active-low and one active-high), write enable, output enable, and one active-low enable per byte lane. The controller also drives the enable of its own data drivers onto a shared bidirectional bus. A read returns its word together with a single-cycle valid pulse.

Every memory timing limit is a parameter in nanoseconds, alongside the clock period. The controller converts each limit into a cycle count by rounding up, with a floor of one cycle. One netlist therefore serves faster and slower memory grades, and only the parameters change. Between any two transfers the controller returns to an idle state, and in that state the memory is deselected.

Top module: `asram_ctrl`

## Requirements
- R1: After synchronous reset, and in every idle cycle, the active-low select is high and the active-high select is low. Write enable, output enable and both lane enables are high. The data drivers are off and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is low until that transfer finishes. While the memory is selected, the address and the lane enables do not change.
- R3: A read selects the memory with output enable low and write enable high for ACC cycles. ACC = ceil(ACC_NS / CLK_NS), with a minimum of 1, which is 4 at the default parameters.
- R4: `rd_data` holds the word sampled from `mem_dq_i` at the clock edge that ends the access cycles. `rd_valid` is high for exactly the one cycle after that edge.
- R5: After a read, the memory stays deselected with output enable high for BR = ceil(REL_NS / CLK_NS) cycles, which is 1 at the default parameters. `mem_dq_oe` is never high while output enable is low, and it is never high within BR cycles after output enable was low.
- R6: A write has three phases. First come AS cycles selected with write enable high. Then write enable is low for WP = max(ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS)) cycles. Then come WR cycles selected with write enable high. The defaults give AS=1, WP=3 and WR=1.
- R7: Output enable stays high through every write phase. `mem_dq_oe` is high, with `mem_dq_o` equal to the request's write data, in all three write phases.
- R8: Request lane bit 0 drives `mem_lb_n`, which covers data bits 7:0. Lane bit 1 drives `mem_ub_n`, which covers bits 15:8. A lane enable is low only while the memory is selected and its lane bit is set. A write with one lane set leaves the other byte of the stored word unchanged.
- R9: After any transfer finishes, there is at least one idle cycle with the memory deselected before the next transfer begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lanes in use (bit 0 low byte, bit 1 high byte) |
| rd_valid | output | 1 | One-cycle read return strobe |
| rd_data | output | 16 | Read word |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | 16 | Data sampled from the memory bus |

## Verification
The sequencer and the interval counter decide every strobe level. If the sequencer sits in a wrong phase, a strobe or `req_ready` differs from the reference within one cycle. If a counter is off by a cycle, a phase is longer or shorter than expected, and that shows at the first phase boundary. The bench memory model returns a deliberately wrong word until the full access time has elapsed. A shortened access therefore appears as bad read data in the cycle after the capture. Byte-lane or merge errors surface only when a later read returns the stored word, so each partial write is followed by reads of that same address. The model also flags any driver enable that overlaps the memory's output or its release window in the same cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACCESS,
        PH_RD_RELEASE,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_RECOVER
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t phase_strobes(input phase_e p);
        strobe_t s;
        s = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (p)
            PH_RD_ACCESS: begin
                s.sel_n = 1'b0; s.sel = 1'b1; s.oe_n = 1'b0;
            end
            PH_WR_SETUP, PH_WR_RECOVER: begin
                s.sel_n = 1'b0; s.sel = 1'b1; s.drive = 1'b1;
            end
            PH_WR_PULSE: begin
                s.sel_n = 1'b0; s.sel = 1'b1; s.we_n = 1'b0; s.drive = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
    parameter int AW = 19,
    parameter int DW = 16,
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [NL-1:0] req_be,
    input  logic          sel_next,
    input  logic          sample,
    input  logic [DW-1:0] dq_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [NL-1:0] lane_n_q,
    output logic [DW-1:0] rdata_q,
    output logic          rvalid_q
);
    logic [NL-1:0] be_q;
    logic [NL-1:0] be_next;

    assign be_next = take ? req_be : be_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    for (genvar g = 0; g < NL; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) lane_n_q[g] <= 1'b1;
            else     lane_n_q[g] <= !(sel_next && be_next[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= sample;
            if (sample) rdata_q <= dq_i;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW      = 19,
    parameter int CLK_NS  = 20,
    parameter int ACC_NS  = 70,
    parameter int WP_NS   = 50,
    parameter int DS_NS   = 30,
    parameter int AS_NS   = 0,
    parameter int WR_NS   = 0,
    parameter int REL_NS  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int ACC_C = ns_to_cycles(ACC_NS, CLK_NS);
    localparam int WP_C  = max_of(ns_to_cycles(WP_NS, CLK_NS), ns_to_cycles(DS_NS, CLK_NS));
    localparam int AS_C  = ns_to_cycles(AS_NS, CLK_NS);
    localparam int WR_C  = ns_to_cycles(WR_NS, CLK_NS);
    localparam int BR_C  = ns_to_cycles(REL_NS, CLK_NS);
    localparam int MAX_C = max_of(max_of(ACC_C, WP_C), max_of(max_of(AS_C, WR_C), BR_C));
    localparam int CW    = $clog2(MAX_C + 1);

    phase_e        ph_q, ph_d;
    strobe_t       strb_q, strb_d;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          t_done;
    logic          take;
    logic          sample;
    logic [LANES-1:0] lane_n;

    assign req_ready = (ph_q == PH_IDLE);
    assign take      = req_valid && req_ready;
    assign sample    = (ph_q == PH_RD_ACCESS) && t_done;

    always_comb begin
        ph_d   = ph_q;
        ld     = 1'b0;
        ld_val = '0;
        case (ph_q)
            PH_IDLE: if (take) begin
                ld = 1'b1;
                if (req_write) begin ph_d = PH_WR_SETUP;  ld_val = CW'(AS_C - 1);  end
                else           begin ph_d = PH_RD_ACCESS; ld_val = CW'(ACC_C - 1); end
            end
            PH_RD_ACCESS:  if (t_done) begin ph_d = PH_RD_RELEASE; ld = 1'b1; ld_val = CW'(BR_C - 1); end
            PH_RD_RELEASE: if (t_done) ph_d = PH_IDLE;
            PH_WR_SETUP:   if (t_done) begin ph_d = PH_WR_PULSE;   ld = 1'b1; ld_val = CW'(WP_C - 1); end
            PH_WR_PULSE:   if (t_done) begin ph_d = PH_WR_RECOVER; ld = 1'b1; ld_val = CW'(WR_C - 1); end
            PH_WR_RECOVER: if (t_done) ph_d = PH_IDLE;
            default:       ph_d = PH_IDLE;
        endcase
    end

    assign strb_d = phase_strobes(ph_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            strb_q <= phase_strobes(PH_IDLE);
        end else begin
            ph_q   <= ph_d;
            strb_q <= strb_d;
        end
    end

    asram_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .done(t_done)
    );

    asram_lanes #(.AW(AW), .DW(DATA_W), .NL(LANES)) u_lanes (
        .clk(clk), .rst(rst), .take(take),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .sel_next(!strb_d.sel_n), .sample(sample), .dq_i(mem_dq_i),
        .addr_q(mem_addr), .wdata_q(mem_dq_o), .lane_n_q(lane_n),
        .rdata_q(rd_data), .rvalid_q(rd_valid)
    );

    assign mem_cs_n  = strb_q.sel_n;
    assign mem_cs    = strb_q.sel;
    assign mem_we_n  = strb_q.we_n;
    assign mem_oe_n  = strb_q.oe_n;
    assign mem_dq_oe = strb_q.drive;
    assign mem_lb_n  = lane_n[0];
    assign mem_ub_n  = lane_n[1];

    // Idle means deselected with every strobe parked (R1)
    p_idle_parked_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    // Address held while selected (R2)
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));

    // Read return is a single-cycle pulse (R4)
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // No driver overlap with memory output or its release cycle (R5)
    p_no_fight_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);
    p_release_gap_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |=> !mem_dq_oe);

    // Write pulse only while selected and driving (R6)
    p_we_selected_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_cs && mem_dq_oe));

    // Output enable kept high during writes (R7)
    p_oe_off_write_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    // Lanes active only while selected (R8)
    p_lanes_selected_r8: assert property (@(posedge clk) disable iff (rst)
        !(mem_lb_n && mem_ub_n) |-> !mem_cs_n);
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int AW     = 19;
    localparam int CLK_NS = 20;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int ACC_CY = cyc(70);
    localparam int WP_CY  = (cyc(50) > cyc(30)) ? cyc(50) : cyc(30);
    localparam int AS_CY  = cyc(0);
    localparam int WR_CY  = cyc(0);
    localparam int BR_CY  = cyc(20);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_be = '0;
    logic req_ready, rd_valid;
    logic [15:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o;
    logic [15:0] sram_out = '0;

    always #10 clk = ~clk;

    asram_ctrl #(.AW(AW), .CLK_NS(CLK_NS)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(sram_out)
    );

    typedef struct packed {
        logic sel_n; logic sel; logic we_n; logic oe_n;
        logic [1:0] be_n; logic drive; logic rv;
        logic [AW-1:0] addr; logic [15:0] data;
    } exp_t;

    typedef struct {
        bit wr; logic [AW-1:0] addr; logic [15:0] data; logic [1:0] be; int gap;
    } op_t;

    exp_t expq[$];
    op_t  ops[$];
    logic [15:0] ref_mem[logic [AW-1:0]];
    logic [15:0] sm_mem[logic [AW-1:0]];
    int n_cmp = 0, n_bad = 0, cyc_n = 0;

    function automatic logic [15:0] init_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {be[1] ? 8'hFF : 8'h00, be[0] ? 8'hFF : 8'h00};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h cycle %0d", req, what, act, expv, cyc_n);
        end
    endtask

    task automatic add_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] be, input int gap);
        op_t o;
        o.wr = wr; o.addr = a; o.data = d; o.be = be; o.gap = gap;
        ops.push_back(o);
    endtask

    task automatic push_expect(input op_t o);
        exp_t e;
        logic [15:0] w;
        w = ref_mem.exists(o.addr) ? ref_mem[o.addr] : init_word(o.addr);
        if (!o.wr) begin
            for (int i = 0; i < ACC_CY; i++) begin
                e = '{sel_n:0, sel:1, we_n:1, oe_n:0, be_n:~o.be, drive:0, rv:0, addr:o.addr, data:'0};
                expq.push_back(e);
            end
            for (int i = 0; i < BR_CY; i++) begin
                e = '{sel_n:1, sel:0, we_n:1, oe_n:1, be_n:2'b11, drive:0, rv:(i == 0),
                      addr:o.addr, data:(w & lane_mask(o.be))};
                expq.push_back(e);
            end
        end else begin
            for (int i = 0; i < AS_CY + WP_CY + WR_CY; i++) begin
                e = '{sel_n:0, sel:1, we_n:!(i >= AS_CY && i < AS_CY + WP_CY), oe_n:1,
                      be_n:~o.be, drive:1, rv:0, addr:o.addr, data:o.data};
                expq.push_back(e);
            end
            ref_mem[o.addr] = (w & ~lane_mask(o.be)) | (o.data & lane_mask(o.be));
        end
    endtask

    // behavioural memory model state
    int rd_cnt = 0, age = 100, wp_cnt = 0;
    bit wr_on = 0;
    logic [AW-1:0] wa;
    logic [15:0] wd;
    logic [1:0] wl;

    task automatic sram_step();
        bit sel, drv, wr;
        logic [1:0] lanes;
        logic [15:0] w;
        sel   = !mem_cs_n && mem_cs;
        lanes = ~{mem_ub_n, mem_lb_n};
        drv   = sel && !mem_oe_n && mem_we_n && (lanes != 2'b00);
        wr    = sel && !mem_we_n && (lanes != 2'b00);
        if (drv) rd_cnt++; else rd_cnt = 0;
        if (drv) age = 0; else if (age < 100) age++;
        if (mem_dq_oe)
            chk(!drv && age > BR_CY, "R5", "driver overlaps memory output", {31'd0, mem_dq_oe}, 32'd0);
        if (wr) begin
            chk(mem_oe_n, "R7", "oe during write", {31'd0, mem_oe_n}, 32'd1);
            wp_cnt++; wa = mem_addr; wd = mem_dq_o; wl = lanes;
        end else if (wr_on) begin
            chk(wp_cnt >= WP_CY, "R6", "write pulse cycles", wp_cnt, WP_CY);
            w = sm_mem.exists(wa) ? sm_mem[wa] : init_word(wa);
            sm_mem[wa] = (w & ~lane_mask(wl)) | (wd & lane_mask(wl));
            wp_cnt = 0;
        end
        wr_on = wr;
        if (drv) begin
            w = sm_mem.exists(mem_addr) ? sm_mem[mem_addr] : init_word(mem_addr);
            sram_out = (rd_cnt >= ACC_CY) ? (w & lane_mask(lanes)) : 16'hBAD0;
        end else begin
            sram_out = 16'h0000;
        end
    endtask

    initial begin
        exp_t e;
        bit busy, prev_busy, pend, done_all;
        op_t cur;
        int gap_left, tail;
        string tg;
        logic [AW-1:0] a1, a2;
        a1 = 19'h7FFF1; a2 = 19'h00022;
        // directed: R8 lane merges, partial-lane reads, empty-lane write
        add_op(0, 19'h00010, 16'h0, 2'b11, 0);
        add_op(1, a1, 16'h1234, 2'b11, 0);
        add_op(0, a1, 16'h0, 2'b11, 0);
        add_op(1, a1, 16'hABCD, 2'b01, 2);
        add_op(0, a1, 16'h0, 2'b11, 0);
        add_op(1, a1, 16'h5678, 2'b10, 0);
        add_op(0, a1, 16'h0, 2'b01, 3);
        add_op(0, a1, 16'h0, 2'b10, 0);
        add_op(1, a2, 16'hFFFF, 2'b00, 0);
        add_op(0, a2, 16'h0, 2'b11, 0);
        for (int i = 0; i < 400; i++)
            add_op($urandom_range(0, 1) == 1, 19'h7FFF0 + AW'($urandom_range(0, 15)),
                   16'($urandom), 2'($urandom_range(0, 3)), $urandom_range(0, 3));

        prev_busy = 0; pend = 0; gap_left = 0; tail = 0; done_all = 0;
        while (!done_all) begin
            @(negedge clk);
            cyc_n++;
            if (cyc_n == 4) rst = 1'b0;
            // compare against expected cycle
            if (expq.size() > 0) begin e = expq.pop_front(); busy = 1; end
            else begin
                e = '{sel_n:1, sel:0, we_n:1, oe_n:1, be_n:2'b11, drive:0, rv:0, addr:'0, data:'0};
                busy = 0;
            end
            if (!e.we_n || e.drive) tg = "R6";
            else if (!e.oe_n) tg = "R3";
            else if (rst) tg = "R1";
            else if (prev_busy) tg = "R9";
            else tg = busy ? "R5" : "R1";
            chk(req_ready == !busy, busy ? "R2" : tg, "ready", {31'd0, req_ready}, {31'd0, !busy});
            chk({mem_cs_n, mem_cs, mem_we_n, mem_oe_n} == {e.sel_n, e.sel, e.we_n, e.oe_n}, tg,
                "strobes cs_n/cs/we_n/oe_n", {28'd0, mem_cs_n, mem_cs, mem_we_n, mem_oe_n},
                {28'd0, e.sel_n, e.sel, e.we_n, e.oe_n});
            chk({mem_ub_n, mem_lb_n} == e.be_n, "R8", "lane enables ub_n/lb_n",
                {30'd0, mem_ub_n, mem_lb_n}, {30'd0, e.be_n});
            if (!e.sel_n) chk(mem_addr == e.addr, "R2", "address", 32'(mem_addr), 32'(e.addr));
            chk(mem_dq_oe == e.drive, "R7", "driver enable", {31'd0, mem_dq_oe}, {31'd0, e.drive});
            if (e.drive) chk(mem_dq_o == e.data, "R7", "write data", 32'(mem_dq_o), 32'(e.data));
            chk(rd_valid == e.rv, "R4", "rd_valid", {31'd0, rd_valid}, {31'd0, e.rv});
            if (e.rv) chk(rd_data == e.data, "R4", "read word (R8 merge)", 32'(rd_data), 32'(e.data));
            prev_busy = busy;
            sram_step();
            // stimulus for the coming edge
            if (!rst && cyc_n > 5) begin
                if (!pend && ops.size() > 0) begin
                    cur = ops.pop_front(); pend = 1; gap_left = cur.gap;
                end
                if (pend && gap_left > 0) begin
                    gap_left--; req_valid = 1'b0;
                end else if (pend) begin
                    req_valid = 1'b1; req_write = cur.wr; req_addr = cur.addr;
                    req_wdata = cur.data; req_be = cur.be;
                    if (req_ready) begin push_expect(cur); pend = 0; end
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (!pend && ops.size() == 0 && expq.size() == 0 && cyc_n > 10) tail++;
            if (tail > 5) done_all = 1;
            if (cyc_n > 150000) begin
                chk(0, "R2", "watchdog expired", cyc_n, 0);
                done_all = 1;
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule